// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interrupt Tracker

This block runs beside the command path of a multi-bank SDRAM controller and follows, bank by bank, what happens when a write burst that carries auto precharge is cut short by a read or write to a different bank. It samples one command per clock: an operation code, a bank, a start column and an auto-precharge flag. From these it reports which burst owns each data-bus cycle and at which column. For the bank that was cut short, it times write recovery from the clock of the interrupting command and then times the precharge. It reports the clock on which that internal precharge begins and the clock from which the bank may be activated again.

Commands that the banks cannot take are rejected. A rejected command raises a one-cycle error flag and changes nothing. This covers any command to a bank that is recovering or precharging, or that still has an auto-precharge burst in flight. Bursts are four beats long and the read latency is three clocks. Write data is always taken as unmasked.

Top module: `wap_intr_tracker`

## Requirements
- R1: Operation codes are 0 = no-op, 1 = activate, 2 = read, 3 = write. A command is illegal if it is an activate to a bank that is not idle, or a read or write to a bank that is not open. A command is also illegal if its bank is in recovery, is precharging, or has an auto-precharge burst in flight. An illegal command raises `cmd_err` for exactly the following cycle and changes no bank state and no beat output.
- R2: A write accepted in cycle c drives `wbeat_vld` high in cycles c to c+3 with that bank on `wbeat_bank`, provided no other read or write is accepted in that window.
- R3: A read or write accepted in cycle k while an earlier burst is still running ends the earlier burst in that same cycle. From cycle k the beat outputs belong to the new command, so the last beat of the earlier write is the one in cycle k-1.
- R4: When the interrupted write carried auto precharge, its bank reads state 2 (recovery) in cycles k+1 to k+TWR. `pchg_begin` for that bank is high in cycle k+TWR+1 only.
- R5: After recovery, the bank reads state 3 (precharging) for TRP cycles and then state 0 (idle). An activate in the last precharging cycle is rejected. An activate one cycle later is accepted, and the bank reads state 1 (open) on the next cycle.
- R6: A write with auto precharge accepted in cycle c and never interrupted keeps its bank in state 1 through cycle c+4. The bank is in recovery from cycle c+5 to c+4+TWR, and `pchg_begin` fires in cycle c+5+TWR.
- R7: A read accepted in cycle c produces read beats on `rbeat_vld`, `rbeat_bank` and `rbeat_col` in cycles c+3 to c+6.
- R8: When a read is cut short by another read, the read data bus switches to the newer burst exactly three cycles after the newer read.
- R9: A read with auto precharge skips recovery. If interrupted in cycle k, its bank precharges from cycle k+1, with `pchg_begin` in k+1. If uncut, it precharges from c+5, with `pchg_begin` in c+5. In both cases it returns to idle after TRP cycles.
- R10: An accepted write cancels every read beat not yet delivered, starting from the write's own cycle. `wbeat_vld` and `rbeat_vld` are never high together.
- R11: Beat i of a burst starting at column s carries column (s with its two low bits replaced by (s+i) mod 4).
- R12: After reset every bank reads state 0, and `wbeat_vld`, `rbeat_vld`, `pchg_begin` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 2 | Operation code of the command in this cycle |
| cmd_bank | input | BA_W | Target bank |
| cmd_col | input | COL_W | Start column (read and write) |
| cmd_ap | input | 1 | Auto-precharge request |
| wbeat_vld | output | 1 | A write beat occupies the bus this cycle |
| wbeat_bank | output | BA_W | Bank owning the write beat |
| wbeat_col | output | COL_W | Column of the write beat |
| rbeat_vld | output | 1 | A read beat occupies the bus this cycle |
| rbeat_bank | output | BA_W | Bank owning the read beat |
| rbeat_col | output | COL_W | Column of the read beat |
| bank_st | output | 2*NB | Per-bank state, two bits per bank: 0 idle, 1 open, 2 recovery, 3 precharging |
| pchg_begin | output | NB | Per-bank pulse in the first precharging cycle |
| cmd_err | output | 1 | Illegal command seen in the previous cycle |

## Verification
A wrong recovery or precharge count shows up at `bank_st` and `pchg_begin` on the first cycle where the bench's expected state differs, which is at most TWR+TRP cycles after the interrupt. It also shows up as a wrongly accepted or rejected activate at the idle boundary. A burst counter that fails to stop on an interrupt puts the wrong bank or column on the beat outputs in the interrupting cycle itself. A read pipeline that is too short, or that is not flushed, shifts or leaks read beats, and this is visible three cycles after the read.

// File: rtl/wap_pkg.sv
package wap_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_OPEN = 2'd1,
    BS_WREC = 2'd2,
    BS_PCHG = 2'd3
  } bst_e;

  // Whether a bank in state st (with an auto-precharge burst pending when
  // lock is set) can take operation op.
  function automatic logic cmd_legal(input op_e op, input bst_e st, input logic lock);
    logic ok;
    unique case (op)
      OP_ACT:       ok = (st == BS_IDLE);
      OP_RD, OP_WR: ok = (st == BS_OPEN) && !lock;
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/wap_bank_fsm.sv
module wap_bank_fsm
  import wap_pkg::*;
#(
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic lock_i,
  input  logic close_wr_i,
  input  logic close_rd_i,
  output bst_e st_o,
  output logic lock_o,
  output logic pchg_begin_o
);
  localparam int CMAX  = (TWR > TRP) ? TWR : TRP;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] TWR_C = CNT_W'(TWR);
  localparam logic [CNT_W-1:0] TRP_C = CNT_W'(TRP);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  bst_e             st;
  logic [CNT_W-1:0] cnt;
  logic             lock, pb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BS_IDLE;
      cnt  <= '0;
      lock <= 1'b0;
      pb   <= 1'b0;
    end else begin
      pb <= 1'b0;
      unique case (st)
        BS_IDLE: if (act_i) st <= BS_OPEN;
        BS_OPEN: begin
          if (close_wr_i) begin
            st <= BS_WREC; cnt <= TWR_C; lock <= 1'b0;
          end else if (close_rd_i) begin
            st <= BS_PCHG; cnt <= TRP_C; lock <= 1'b0; pb <= 1'b1;
          end else if (lock_i) begin
            lock <= 1'b1;
          end
        end
        BS_WREC: begin
          if (cnt == ONE_C) begin
            st <= BS_PCHG; cnt <= TRP_C; pb <= 1'b1;
          end else begin
            cnt <= cnt - ONE_C;
          end
        end
        BS_PCHG: begin
          if (cnt == ONE_C) st <= BS_IDLE;
          else              cnt <= cnt - ONE_C;
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  assign st_o         = st;
  assign lock_o       = lock;
  assign pchg_begin_o = pb;

  // Recovery always hands over to precharge with the begin pulse.
  assert_wrec_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_WREC && cnt == ONE_C) |=> (st == BS_PCHG && pb));
  // Precharge ends in idle.
  assert_pchg_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_PCHG && cnt == ONE_C) |=> (st == BS_IDLE));
  // A close request from the burst tracker only ever hits a locked open bank.
  assert_close_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_wr_i || close_rd_i) |-> (st == BS_OPEN && lock));
  // The begin pulse marks the first precharge cycle.
  assert_pb_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pb |-> (st == BS_PCHG && cnt == TRP_C));

endmodule

// File: rtl/wap_burst_ctl.sv
module wap_burst_ctl
  import wap_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int COL_W = 9,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [COL_W-1:0] col_i,
  output logic             beat_vld_o,
  output logic             beat_wr_o,
  output logic [BA_W-1:0]  beat_bank_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             close_vld_o,
  output logic             close_wr_o,
  output logic [BA_W-1:0]  close_bank_o
);
  localparam int IDX_W = $clog2(BL);
  localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

  // Column of beat idx within an aligned block of BL columns.
  function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    logic [COL_W-1:0] m;
    m = COL_W'(BL - 1);
    return (base & ~m) | ((base + COL_W'(idx)) & m);
  endfunction

  // Beat index from the count of beats still to come.
  function automatic logic [IDX_W-1:0] beat_idx(input logic [IDX_W-1:0] rem);
    return IDX_W'(BL) - rem;
  endfunction

  logic [IDX_W-1:0] left;
  logic [BA_W-1:0]  bank_q, tail_bank_q;
  logic [COL_W-1:0] base_q;
  logic             wr_q, ap_q, tail_q, tail_wr_q;
  logic             live;

  assign live         = (left != '0);
  assign beat_vld_o   = acc_i || live;
  assign beat_wr_o    = acc_i ? wr_i   : wr_q;
  assign beat_bank_o  = acc_i ? bank_i : bank_q;
  assign beat_col_o   = acc_i ? col_i  : wrap_col(base_q, beat_idx(left));
  assign close_vld_o  = (acc_i && live && ap_q) || tail_q;
  assign close_wr_o   = tail_q ? tail_wr_q   : wr_q;
  assign close_bank_o = tail_q ? tail_bank_q : bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0; bank_q <= '0; base_q <= '0; wr_q <= 1'b0; ap_q <= 1'b0;
      tail_q <= 1'b0; tail_bank_q <= '0; tail_wr_q <= 1'b0;
    end else begin
      tail_q <= 1'b0;
      if (acc_i) begin
        left   <= IDX_W'(BL - 1);
        bank_q <= bank_i;
        base_q <= col_i;
        wr_q   <= wr_i;
        ap_q   <= ap_i;
      end else if (live) begin
        left <= left - ONE_I;
        if (left == ONE_I && ap_q) begin
          tail_q      <= 1'b1;
          tail_bank_q <= bank_q;
          tail_wr_q   <= wr_q;
        end
      end
    end
  end

  // The end-of-burst close never coincides with a running burst.
  assert_tail_after_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> !live);

endmodule

// File: rtl/wap_rd_pipe.sv
module wap_rd_pipe #(
  parameter int BA_W  = 2,
  parameter int COL_W = 9,
  parameter int CL    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             flush_i,
  output logic             vld_o,
  output logic [BA_W-1:0]  bank_o,
  output logic [COL_W-1:0] col_o
);
  logic [CL-1:0]    v;
  logic [BA_W-1:0]  b [CL];
  logic [COL_W-1:0] c [CL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0;
      for (int i = 0; i < CL; i++) begin
        b[i] <= '0;
        c[i] <= '0;
      end
    end else if (flush_i) begin
      v <= '0;
    end else begin
      v[0] <= push_i;
      b[0] <= bank_i;
      c[0] <= col_i;
      for (int i = 1; i < CL; i++) begin
        v[i] <= v[i-1];
        b[i] <= b[i-1];
        c[i] <= c[i-1];
      end
    end
  end

  assign vld_o  = v[CL-1] && !flush_i;
  assign bank_o = b[CL-1];
  assign col_o  = c[CL-1];

  // A flush leaves nothing in flight.
  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !vld_o);

endmodule

// File: rtl/wap_intr_tracker.sv
module wap_intr_tracker
  import wap_pkg::*;
#(
  parameter int NB    = 4,
  parameter int COL_W = 9,
  parameter int BL    = 4,
  parameter int CL    = 3,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  localparam int BA_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_ap,
  output logic              wbeat_vld,
  output logic [BA_W-1:0]   wbeat_bank,
  output logic [COL_W-1:0]  wbeat_col,
  output logic              rbeat_vld,
  output logic [BA_W-1:0]   rbeat_bank,
  output logic [COL_W-1:0]  rbeat_col,
  output logic [2*NB-1:0]   bank_st,
  output logic [NB-1:0]     pchg_begin,
  output logic              cmd_err
);
  op_e              op;
  bst_e             st_arr [NB];
  logic [NB-1:0]    lock_arr;
  bst_e             sel_st;
  logic             sel_lock, is_cmd, cmd_ok, acc, rw_acc, act_acc, err_q;
  logic             beat_vld, beat_wr, close_vld, close_wr;
  logic [BA_W-1:0]  beat_bank, close_bank;
  logic [COL_W-1:0] beat_col;

  assign op       = op_e'(cmd_op);
  assign sel_st   = st_arr[cmd_bank];
  assign sel_lock = lock_arr[cmd_bank];
  assign is_cmd   = (op != OP_NOP);
  assign cmd_ok   = cmd_legal(op, sel_st, sel_lock);
  assign acc      = is_cmd && cmd_ok;
  assign rw_acc   = acc && (op == OP_RD || op == OP_WR);
  assign act_acc  = acc && (op == OP_ACT);

  wap_burst_ctl #(.BA_W(BA_W), .COL_W(COL_W), .BL(BL)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .acc_i(rw_acc), .wr_i(op == OP_WR), .ap_i(cmd_ap),
    .bank_i(cmd_bank), .col_i(cmd_col),
    .beat_vld_o(beat_vld), .beat_wr_o(beat_wr),
    .beat_bank_o(beat_bank), .beat_col_o(beat_col),
    .close_vld_o(close_vld), .close_wr_o(close_wr), .close_bank_o(close_bank)
  );

  wap_rd_pipe #(.BA_W(BA_W), .COL_W(COL_W), .CL(CL)) u_rdp (
    .clk(clk), .rst_n(rst_n),
    .push_i(beat_vld && !beat_wr), .bank_i(beat_bank), .col_i(beat_col),
    .flush_i(rw_acc && op == OP_WR),
    .vld_o(rbeat_vld), .bank_o(rbeat_bank), .col_o(rbeat_col)
  );

  assign wbeat_vld  = beat_vld && beat_wr;
  assign wbeat_bank = beat_bank;
  assign wbeat_col  = beat_col;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit, close_hit;
    assign hit       = (cmd_bank == BA_W'(g));
    assign close_hit = close_vld && (close_bank == BA_W'(g));
    wap_bank_fsm #(.TWR(TWR), .TRP(TRP)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_acc && hit),
      .lock_i(rw_acc && cmd_ap && hit),
      .close_wr_i(close_hit && close_wr),
      .close_rd_i(close_hit && !close_wr),
      .st_o(st_arr[g]), .lock_o(lock_arr[g]), .pchg_begin_o(pchg_begin[g])
    );
    assign bank_st[2*g +: 2] = st_arr[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= is_cmd && !cmd_ok;
  end
  assign cmd_err = err_q;

  // An error flag always follows a real command.
  assert_err_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($past(cmd_op) != 2'd0));
  // Commands to a busy bank are rejected.
  assert_busy_rejects_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && (sel_st == BS_WREC || sel_st == BS_PCHG)) |=> cmd_err);
  // The owner of a write beat is always an open bank.
  assert_wbeat_owner_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wbeat_vld |-> (st_arr[wbeat_bank] == BS_OPEN));
  // Read and write beats never share a cycle.
  assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wbeat_vld && rbeat_vld));

endmodule

// File: tb/sim_wap_intr_tracker.sv
module sim_wap_intr_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, COL_W = 9, BL = 4, CL = 3, TWR = 2, TRP = 3;
  localparam int BA_W = 2;
  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd_op = NOP;
  logic [BA_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic cmd_ap = 1'b0;
  logic wbeat_vld, rbeat_vld, cmd_err;
  logic [BA_W-1:0] wbeat_bank, rbeat_bank;
  logic [COL_W-1:0] wbeat_col, rbeat_col;
  logic [2*NB-1:0] bank_st;
  logic [NB-1:0] pchg_begin;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wap_intr_tracker #(.NB(NB), .COL_W(COL_W), .BL(BL), .CL(CL), .TWR(TWR), .TRP(TRP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .wbeat_vld(wbeat_vld), .wbeat_bank(wbeat_bank), .wbeat_col(wbeat_col),
    .rbeat_vld(rbeat_vld), .rbeat_bank(rbeat_bank), .rbeat_col(rbeat_col),
    .bank_st(bank_st), .pchg_begin(pchg_begin), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ecol(input int base, input int idx);
    return (base / 4) * 4 + ((base + idx) % 4);
  endfunction

  function automatic int stb(input int b);
    return int'(bank_st[2*b +: 2]);
  endfunction

  task automatic drive(input logic [1:0] op, input int bank, input int col, input logic ap);
    @(negedge clk);
    cmd_op = op; cmd_bank = BA_W'(bank); cmd_col = COL_W'(col); cmd_ap = ap;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_op = NOP; cmd_ap = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int b = 0; b < NB; b++) chk("R12 reset bank state", stb(b), 0);
    chk("R12 reset wbeat", int'(wbeat_vld), 0);
    chk("R12 reset rbeat", int'(rbeat_vld), 0);
    chk("R12 reset pchg", int'(pchg_begin), 0);
    chk("R12 reset err", int'(cmd_err), 0);
  endtask

  // Uncut write with auto precharge, plus an illegal write to the locked bank.
  task automatic t_uncut_write();
    int es;
    do_reset();
    for (int j = 0; j <= 12; j++) begin
      case (j)
        0: drive(ACT, 0, 0, 1'b0);
        1: drive(WR, 0, 5, 1'b1);
        3: drive(WR, 0, 0, 1'b0);
        default: drive(NOP, 0, 0, 1'b0);
      endcase
      chk("R2 wbeat_vld", int'(wbeat_vld), (j >= 1 && j <= 4) ? 1 : 0);
      if (j >= 1 && j <= 4) begin
        chk("R2 wbeat_bank", int'(wbeat_bank), 0);
        chk("R11 wbeat_col", int'(wbeat_col), ecol(5, j - 1));
      end
      chk("R1 err locked bank", int'(cmd_err), (j == 4) ? 1 : 0);
      es = (j == 0) ? 0 : (j <= 5) ? 1 : (j <= 5 + TWR) ? 2 : (j <= 5 + TWR + TRP) ? 3 : 0;
      chk("R6 bank0 state", stb(0), es);
      chk("R6 pchg_begin", int'(pchg_begin[0]), (j == 6 + TWR) ? 1 : 0);
    end
  endtask

  // Write with auto precharge cut short by a write to another bank.
  task automatic t_write_intr();
    int es;
    do_reset();
    for (int j = 0; j <= 11; j++) begin
      case (j)
        0: drive(ACT, 1, 0, 1'b0);
        1: drive(ACT, 2, 0, 1'b0);
        2: drive(WR, 1, 8, 1'b1);
        4: drive(WR, 2, 16, 1'b0);
        4 + TWR + TRP: drive(ACT, 1, 0, 1'b0);
        5 + TWR + TRP: drive(ACT, 1, 0, 1'b0);
        default: drive(NOP, 0, 0, 1'b0);
      endcase
      chk("R3 wbeat_vld", int'(wbeat_vld), (j >= 2 && j <= 7) ? 1 : 0);
      if (j >= 2 && j <= 3) begin
        chk("R3 wbeat_bank first", int'(wbeat_bank), 1);
        chk("R11 wbeat_col first", int'(wbeat_col), ecol(8, j - 2));
      end
      if (j >= 4 && j <= 7) begin
        chk("R3 wbeat_bank second", int'(wbeat_bank), 2);
        chk("R11 wbeat_col second", int'(wbeat_col), ecol(16, j - 4));
      end
      es = (j == 0) ? 0 : (j <= 4) ? 1 : (j <= 4 + TWR) ? 2 :
           (j <= 4 + TWR + TRP) ? 3 : (j == 5 + TWR + TRP) ? 0 : 1;
      chk("R4 R5 bank1 state", stb(1), es);
      chk("R4 pchg_begin", int'(pchg_begin[1]), (j == 5 + TWR) ? 1 : 0);
      chk("R5 err on early activate", int'(cmd_err), (j == 5 + TWR + TRP) ? 1 : 0);
      if (j >= 2) chk("R3 bank2 open", stb(2), 1);
    end
  endtask

  // Read with auto precharge cut by a read, then an uncut read with auto precharge.
  task automatic t_read_intr();
    int es0, es3;
    do_reset();
    for (int j = 0; j <= 17; j++) begin
      case (j)
        0: drive(ACT, 0, 0, 1'b0);
        1: drive(ACT, 3, 0, 1'b0);
        2: drive(RD, 0, 0, 1'b1);
        3: drive(RD, 3, 32, 1'b0);
        8: drive(RD, 3, 40, 1'b1);
        default: drive(NOP, 0, 0, 1'b0);
      endcase
      chk("R10 no wbeat on reads", int'(wbeat_vld), 0);
      chk("R7 rbeat_vld", int'(rbeat_vld), (j >= 5 && j <= 9) || (j >= 11 && j <= 14) ? 1 : 0);
      if (j == 5) begin
        chk("R7 rbeat_bank", int'(rbeat_bank), 0);
        chk("R11 rbeat_col", int'(rbeat_col), 0);
      end
      if (j >= 6 && j <= 9) begin
        chk("R8 rbeat_bank switch", int'(rbeat_bank), 3);
        chk("R8 rbeat_col", int'(rbeat_col), ecol(32, j - 6));
      end
      if (j >= 11 && j <= 14) begin
        chk("R7 rbeat_bank later", int'(rbeat_bank), 3);
        chk("R11 rbeat_col later", int'(rbeat_col), ecol(40, j - 11));
      end
      es0 = (j == 0) ? 0 : (j <= 3) ? 1 : (j <= 3 + TRP) ? 3 : 0;
      es3 = (j <= 1) ? 0 : (j <= 12) ? 1 : (j <= 12 + TRP) ? 3 : 0;
      chk("R9 bank0 state", stb(0), es0);
      chk("R9 bank3 state", stb(3), es3);
      chk("R9 pchg0", int'(pchg_begin[0]), (j == 4) ? 1 : 0);
      chk("R9 pchg3", int'(pchg_begin[3]), (j == 13) ? 1 : 0);
    end
  endtask

  // A write flushes pending read data; illegal activate and write to idle bank.
  task automatic t_flush_and_illegal();
    do_reset();
    for (int j = 0; j <= 9; j++) begin
      case (j)
        0: drive(ACT, 0, 0, 1'b0);
        1: drive(ACT, 3, 0, 1'b0);
        2: drive(RD, 3, 0, 1'b0);
        3: drive(WR, 0, 4, 1'b0);
        6: drive(ACT, 0, 0, 1'b0);
        7: drive(WR, 1, 12, 1'b0);
        default: drive(NOP, 0, 0, 1'b0);
      endcase
      chk("R10 read flushed", int'(rbeat_vld), 0);
      chk("R10 wbeat_vld", int'(wbeat_vld), (j >= 3 && j <= 6) ? 1 : 0);
      if (j >= 3 && j <= 6) begin
        chk("R10 wbeat_bank", int'(wbeat_bank), 0);
        chk("R11 wbeat_col", int'(wbeat_col), ecol(4, j - 3));
      end
      chk("R1 err illegal", int'(cmd_err), (j == 7 || j == 8) ? 1 : 0);
      if (j >= 1) chk("R1 bank0 unchanged", stb(0), 1);
      chk("R1 bank1 unchanged", stb(1), 0);
    end
  endtask

  initial begin
    t_uncut_write();
    t_write_intr();
    t_read_intr();
    t_flush_and_illegal();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule